// File: doc/BRIEF.md
# Serial Memory Write Guard

This block sits behind the command decoder of a serial nonvolatile memory slave with a 2K x 8 array. It holds the write-enable latch and the protection bits of the status register. It turns decoded one-cycle command strobes into two results: a per-byte permit for array writes, and an accept for status register writes. The front end shifts the live status byte out whenever the host asks for it.

Array writes depend on two things: the write-enable latch, and a two-bit block-protect field that protects a quarter, half or all of the top of the address space. The external active-low protect pin blocks only status register updates. Any command that writes disarms the latch when chip select rises at the end of its frame. A frame that only sets the latch keeps it armed for the next frame.

Top module: `wp_guard`

## Requirements
- R1: After reset the status byte reads 0x00. The protect-enable bit (bit 7), the block-protect field (bits 3:2) and the write-enable latch (bit 1) are all clear.
- R2: A write-enable strobe sets status bit 1 on the next clock. A write-disable strobe clears it on the next clock.
- R3: A rising edge of the chip-select input clears the latch, but only if a status write strobe or array write strobe was seen since chip select fell, whether or not that write was accepted. A frame with no write strobe leaves the latch unchanged.
- R4: Status bits 6:4 and bit 0 (ready, never busy) always read 0, whatever data a status write carries in those positions.
- R5: A status write strobe raises `wrsr_ok_o` in the same cycle only when the latch is set and `wp_n_i` is high. Only then are bits 7 and 3:2 of `wrsr_data_i` stored, visible on the next clock. Otherwise the status byte is unchanged.
- R6: `mem_wr_ok_o` is never high while the latch is clear.
- R7: The block-protect field, read as bit 3 then bit 2, sets the blocked addresses. 00 blocks none. 01 blocks 0x600–0x7FF. 10 blocks 0x400–0x7FF. 11 blocks 0x000–0x7FF. With the latch set, an array write strobe to an unblocked address raises `mem_wr_ok_o` in the same cycle, and one to a blocked address does not.
- R8: The level of `wp_n_i` has no effect on `mem_wr_ok_o`.
- R9: `status_o` always shows the current stored contents. Observing it changes no state.
- R10: The permit is evaluated on every byte of a multi-byte write. A burst that crosses into a blocked range loses its permit from the first blocked address on, and the latch stays set until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip-select level, active low |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_wren_i | input | 1 | Write-enable command strobe |
| cmd_wrdi_i | input | 1 | Write-disable command strobe |
| cmd_wrsr_i | input | 1 | Status write strobe |
| wrsr_data_i | input | 8 | Byte carried by the status write |
| cmd_wrmem_i | input | 1 | Array byte write strobe |
| addr_i | input | 11 | Target array byte address |
| status_o | output | 8 | Live status byte |
| wrsr_ok_o | output | 1 | Status write accepted this cycle |
| mem_wr_ok_o | output | 1 | Array byte write permitted this cycle |

## Verification
The properties assume that the command strobes arrive only while chip select is low. They also assume at most one strobe is active in any cycle, and that chip select never rises in the cycle of a strobe. The bench meets these assumptions by building every transaction from tasks. Each task lowers chip select first, raises one strobe for a single clock, and raises chip select only after the strobes are idle. The protect pin is moved only between strobes, so each cycle sees one fixed level.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned ADDR_W  = 11;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned SB_WPEN = 7;
  localparam int unsigned SB_BPH  = 3;
  localparam int unsigned SB_BPL  = 2;
  localparam int unsigned SB_WEL  = 1;
  localparam int unsigned SB_RDY  = 0;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_e;
endpackage

// File: rtl/wp_wel_latch.sv
module wp_wel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic wr_cmd_i,
  output logic wel_o
);
  logic cs_n_q, wr_seen_q, wel_q;
  logic cs_rise, wr_seen_d, wel_d, wel_en, seen_en;

  always_comb begin
    cs_rise   = cs_n_i & ~cs_n_q;
    seen_en   = cs_rise | wr_cmd_i;
    wr_seen_d = cs_rise ? 1'b0 : 1'b1;
    wel_en    = wren_i | wrdi_i | (cs_rise & wr_seen_q);
    wel_d     = wel_q;
    if (wren_i) wel_d = 1'b1;
    if (wrdi_i) wel_d = 1'b0;
    if (cs_rise && wr_seen_q) wel_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q    <= 1'b1;
      wr_seen_q <= 1'b0;
      wel_q     <= 1'b0;
    end else begin
      cs_n_q <= cs_n_i;
      if (seen_en) wr_seen_q <= wr_seen_d;
      if (wel_en)  wel_q     <= wel_d;
    end
  end

  assign wel_o = wel_q;
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
  import wp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic              wpen_o,
  output logic [1:0]        bp_o
);
  logic       wpen_q, wpen_d;
  logic [1:0] bp_q, bp_d;
  logic       unused_bits;

  always_comb begin
    wpen_d = wr_data_i[SB_WPEN];
    bp_d   = {wr_data_i[SB_BPH], wr_data_i[SB_BPL]};
  end

  assign unused_bits = ^{wr_data_i[6:4], wr_data_i[SB_WEL], wr_data_i[SB_RDY]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wpen_q <= 1'b0;
      bp_q   <= 2'b00;
    end else if (wr_en_i) begin
      wpen_q <= wpen_d;
      bp_q   <= bp_d;
    end
  end

  assign wpen_o = wpen_q;
  assign bp_o   = bp_q;
endmodule

// File: rtl/wp_block_decode.sv
module wp_block_decode
  import wp_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [1:0]    bp_i,
  input  logic [AW-1:0] addr_i,
  output logic          blocked_o
);
  localparam int unsigned TOPW = 2;
  logic [TOPW-1:0] top;
  logic            unused_low;

  assign top        = addr_i[AW-1 -: TOPW];
  assign unused_low = ^addr_i[AW-TOPW-1:0];

  always_comb begin
    unique case (prot_e'(bp_i))
      PROT_NONE:    blocked_o = 1'b0;
      PROT_QUARTER: blocked_o = (top == 2'b11);
      PROT_HALF:    blocked_o = top[TOPW-1];
      default:      blocked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wp_n_i,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [STAT_W-1:0] wrsr_data_i,
  input  logic              cmd_wrmem_i,
  input  logic [AW-1:0]     addr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              wrsr_ok_o,
  output logic              mem_wr_ok_o
);
  logic       wel, wpen, blocked;
  logic [1:0] bp;

  wp_wel_latch u_wel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_i   (cs_n_i),
    .wren_i   (cmd_wren_i),
    .wrdi_i   (cmd_wrdi_i),
    .wr_cmd_i (cmd_wrsr_i | cmd_wrmem_i),
    .wel_o    (wel)
  );

  assign wrsr_ok_o = cmd_wrsr_i & wel & wp_n_i;

  wp_status_reg u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wrsr_ok_o),
    .wr_data_i (wrsr_data_i),
    .wpen_o    (wpen),
    .bp_o      (bp)
  );

  wp_block_decode #(.AW(AW)) u_dec (
    .bp_i      (bp),
    .addr_i    (addr_i),
    .blocked_o (blocked)
  );

  assign mem_wr_ok_o = cmd_wrmem_i & wel & ~blocked;

  always_comb begin
    status_o          = '0;
    status_o[SB_WPEN] = wpen;
    status_o[SB_BPH]  = bp[1];
    status_o[SB_BPL]  = bp[0];
    status_o[SB_WEL]  = wel;
    status_o[SB_RDY]  = 1'b0;
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_n_i,
  input logic          wp_n_i,
  input logic          cmd_wren_i,
  input logic          cmd_wrdi_i,
  input logic          cmd_wrsr_i,
  input logic          cmd_wrmem_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    status_o,
  input logic          wrsr_ok_o,
  input logic          mem_wr_ok_o
);
  AST_WREN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wren_i && !cmd_wrdi_i && !cs_n_i) |=> status_o[1]); // R2
  AST_WRDI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wrdi_i |=> !status_o[1]); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6:4] == 3'b000) && !status_o[0]); // R4
  AST_PIN_BLOCKS_WRSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_n_i |-> !wrsr_ok_o); // R5
  AST_PROT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrsr_ok_o |=> $stable({status_o[7], status_o[3:2]})); // R5
  AST_MEM_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_ok_o |-> status_o[1]); // R6
  AST_ALL_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3:2] == 2'b11) |-> !mem_wr_ok_o); // R7
  AST_QUARTER_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3:2] == 2'b01 && status_o[1] && cmd_wrmem_i && addr_i[AW-1:AW-2] != 2'b11)
      |-> mem_wr_ok_o); // R10
  AST_QUIET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_wren_i && !cmd_wrdi_i && !cmd_wrsr_i && !cs_n_i) |=> $stable(status_o)); // R9
endmodule

bind wp_guard wp_guard_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_i      (cs_n_i),
  .wp_n_i      (wp_n_i),
  .cmd_wren_i  (cmd_wren_i),
  .cmd_wrdi_i  (cmd_wrdi_i),
  .cmd_wrsr_i  (cmd_wrsr_i),
  .cmd_wrmem_i (cmd_wrmem_i),
  .addr_i      (addr_i),
  .status_o    (status_o),
  .wrsr_ok_o   (wrsr_ok_o),
  .mem_wr_ok_o (mem_wr_ok_o)
);

// File: tb/wp_guard_test.sv
module wp_guard_test;
  logic        clk_i = 1'b0;
  logic        rst_ni, cs_n_i, wp_n_i;
  logic        cmd_wren_i, cmd_wrdi_i, cmd_wrsr_i, cmd_wrmem_i;
  logic [7:0]  wrsr_data_i;
  logic [10:0] addr_i;
  logic [7:0]  status_o;
  logic        wrsr_ok_o, mem_wr_ok_o;
  int          n_checks = 0;
  int          n_errors = 0;
  logic        ok;

  // vector: {bp[1:0], wp_n, expected permit, addr[10:0]}
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    {2'b00, 1'b1, 1'b1, 11'h000},
    {2'b00, 1'b0, 1'b1, 11'h7FF},
    {2'b01, 1'b1, 1'b1, 11'h5FF},
    {2'b01, 1'b1, 1'b0, 11'h600},
    {2'b01, 1'b0, 1'b0, 11'h7FF},
    {2'b10, 1'b1, 1'b1, 11'h3FF},
    {2'b10, 1'b1, 1'b0, 11'h400},
    {2'b10, 1'b0, 1'b1, 11'h000},
    {2'b11, 1'b1, 1'b0, 11'h000},
    {2'b11, 1'b1, 1'b0, 11'h3A5},
    {2'b11, 1'b0, 1'b0, 11'h7FF},
    {2'b01, 1'b0, 1'b1, 11'h000}
  };

  always #4 clk_i = ~clk_i;

  wp_guard uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .wp_n_i(wp_n_i),
    .cmd_wren_i(cmd_wren_i), .cmd_wrdi_i(cmd_wrdi_i), .cmd_wrsr_i(cmd_wrsr_i),
    .wrsr_data_i(wrsr_data_i), .cmd_wrmem_i(cmd_wrmem_i), .addr_i(addr_i),
    .status_o(status_o), .wrsr_ok_o(wrsr_ok_o), .mem_wr_ok_o(mem_wr_ok_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    @(negedge clk_i); cs_n_i = 1'b0;
  endtask

  task automatic cs_high();
    @(negedge clk_i); cs_n_i = 1'b1;
    @(negedge clk_i); #1;
  endtask

  task automatic do_wren();
    @(negedge clk_i); cmd_wren_i = 1'b1;
    @(negedge clk_i); cmd_wren_i = 1'b0; #1;
  endtask

  task automatic do_wrdi();
    @(negedge clk_i); cmd_wrdi_i = 1'b1;
    @(negedge clk_i); cmd_wrdi_i = 1'b0; #1;
  endtask

  task automatic do_wrsr(input logic [7:0] d, output logic acc);
    @(negedge clk_i); wrsr_data_i = d; cmd_wrsr_i = 1'b1;
    #1 acc = wrsr_ok_o;
    @(negedge clk_i); cmd_wrsr_i = 1'b0; wrsr_data_i = 8'h00; #1;
  endtask

  task automatic mem_try(input logic [10:0] a, output logic acc);
    @(negedge clk_i); addr_i = a; cmd_wrmem_i = 1'b1;
    #1 acc = mem_wr_ok_o;
    @(negedge clk_i); cmd_wrmem_i = 1'b0; #1;
  endtask

  task automatic set_bp(input logic [1:0] bp);
    logic acc;
    wp_n_i = 1'b1;
    cs_low(); do_wren(); do_wrsr({4'b0000, bp, 2'b00}, acc); cs_high();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cs_n_i = 1'b1; wp_n_i = 1'b1;
    cmd_wren_i = 0; cmd_wrdi_i = 0; cmd_wrsr_i = 0; cmd_wrmem_i = 0;
    wrsr_data_i = 8'h00; addr_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check("R1 reset status", status_o, 8'h00);

    // table walk: protection ranges and pin independence
    for (int i = 0; i < NV; i++) begin
      set_bp(VEC[i][14:13]);
      check("R7 bp stored", status_o, {4'b0000, VEC[i][14:13], 2'b00});
      cs_low(); do_wren();
      wp_n_i = VEC[i][12];
      mem_try(VEC[i][10:0], ok);
      check((VEC[i][12] == 1'b0) ? "R8 pin ignored for array" : "R7 range permit",
            ok, VEC[i][11]);
      cs_high();
      check("R3 cleared after array frame", status_o[1], 1'b0);
      wp_n_i = 1'b1;
    end
    set_bp(2'b00);

    // latch set/clear and frames without writes
    cs_low(); do_wren();
    check("R2 wren sets latch", status_o, 8'h02);
    repeat (3) @(negedge clk_i); #1;
    check("R9 status steady while observed", status_o, 8'h02);
    cs_high();
    check("R3 no-write frame keeps latch", status_o, 8'h02);
    cs_low(); do_wrdi();
    check("R2 wrdi clears latch", status_o, 8'h00);
    mem_try(11'h010, ok);
    check("R6 no permit without latch", ok, 1'b0);
    do_wrsr(8'h8C, ok);
    check("R5 rejected without latch", ok, 1'b0);
    check("R5 status unchanged", status_o, 8'h00);
    cs_high();

    // pin blocks status write, frame still disarms latch
    cs_low(); do_wren(); wp_n_i = 1'b0;
    do_wrsr(8'h8C, ok);
    check("R5 pin low rejects", ok, 1'b0);
    check("R5 status kept", status_o, 8'h02);
    cs_high();
    check("R3 rejected write still ends cycle", status_o, 8'h00);
    wp_n_i = 1'b1;

    // accepted write with reserved bits set
    cs_low(); do_wren();
    do_wrsr(8'hFF, ok);
    check("R5 accepted", ok, 1'b1);
    check("R4 reserved read zero", status_o, 8'h8E);
    cs_high();
    check("R3 latch cleared after status write", status_o, 8'h8C);
    cs_low(); do_wren();
    mem_try(11'h000, ok);
    check("R7 all blocked", ok, 1'b0);
    cs_high();

    // burst across the quarter boundary
    set_bp(2'b01);
    cs_low(); do_wren();
    mem_try(11'h5FE, ok); check("R10 burst byte 0", ok, 1'b1);
    mem_try(11'h5FF, ok); check("R10 burst byte 1", ok, 1'b1);
    mem_try(11'h600, ok); check("R10 burst byte 2", ok, 1'b0);
    mem_try(11'h601, ok); check("R10 burst byte 3", ok, 1'b0);
    check("R10 latch held in burst", status_o[1], 1'b1);
    cs_high();
    check("R3 latch cleared after burst", status_o, 8'h04);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule